// File: doc/BRIEF.md
# ADC Link Bring-Up Sequencer

This controller takes a high-speed converter with a serial output link from the moment its supplies are good to the point where the link is aligned. After a start pulse, it waits until the power-good input has been high without a break for a minimum power-on time. It then drives an active-high hardware reset for a minimum width and waits a minimum settling gap. The delays are set by parameters in nanoseconds and the clock frequency, and each is rounded up to whole cycles.

Next it runs a fixed, order-sensitive script of register writes. Each write goes out as a request to an external serial-bus master and is held until that master acknowledges it. The script first applies a soft reset and clears the unused pages. It then sets the performance bits and selects the lane count. Then it programs the decimation filter and pulses the reset that applies those settings, and finally it loads the multiframe length K. Register pages are reached through a two-register page pointer. Some write values depend on the chosen lane mode and filter type.

At the end the controller holds the link SYNC line low for a programmable number of cycles, so the transmitter can send its comma characters, and then releases it high. The mode inputs and the K override are captured at the start. The K actually applied, and the highest reference-pulse frequency that this K permits, are available as status outputs.

Top module: `adc_link_bringup_seq`

## Requirements
- R1: While rst_n is low and after it is released, adc_rst_o, wr_req_o, busy_o, done_o and sync_o are 0, k_applied_o is 8 and ref_max_hz_o is 27777777.
- R2: After an accepted start, adc_rst_o rises only once pwr_good_i has been high for ceil(PWRON_NS*CLK_HZ/1e9) consecutive cycles. A low cycle on pwr_good_i restarts this count.
- R3: adc_rst_o stays high for exactly ceil(RST_NS*CLK_HZ/1e9) cycles. The first write request appears exactly ceil(POST_NS*CLK_HZ/1e9) cycles after it falls. No request is made while adc_rst_o is high.
- R4: Each write is shown as wr_bank_o (4 bits), wr_offs_o (12 bits) and wr_data_o (8 bits). The 28 writes come in this order, written as bank-offset=data in hex. Soft reset: 0-000=81, 4-001=00, 4-002=00, 4-003=00, 4-004=68, 6-0F7=01, 6-000=01, 6-000=00. Performance: 0-011=80, 0-059=20. Lanes: 4-003=00, 4-004=69, 6-000=80, 6-001=L1, 4-003=00, 4-004=6A, 6-016=L2. Filter: 4-003=00, 4-004=68, 6-052=80, 6-072=08, 6-04D=08, 6-041=F, 6-000=01, 6-000=00. K: 4-003=00, 4-004=69, 6-006={000,K}.
- R5: With lane2_i=0 (four lanes), L1=01 and L2=00. With lane2_i=1 (two lanes), L1=02 and L2=02. F is 12 for hpf_i=0 (low-pass) and 16 for hpf_i=1 (high-pass).
- R6: wr_req_o stays high with stable bank, offset and data until a cycle in which wr_ack_i is high. The next step appears in the following cycle.
- R7: K equals k_ovr_i captured at start. An override of 0 is replaced by 8 in four-lane mode or 4 in two-lane mode.
- R8: ref_max_hz_o equals floor(250000000/(k_applied_o+1)). For example, K=31 gives 7812500.
- R9: After the last acknowledge, sync_o stays low for SYNC_LOW_CYC cycles and then goes high together with done_o.
- R10: busy_o is high from the cycle after an accepted start until sync_o rises. done_o stays set until the next accepted start. A start pulse while busy_o is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, accepted only while idle |
| pwr_good_i | input | 1 | Converter supplies good |
| lane2_i | input | 1 | 1 selects two-lane mode, 0 selects four-lane mode |
| hpf_i | input | 1 | 1 selects the high-pass filter, 0 selects the low-pass filter |
| k_ovr_i | input | 5 | K override, 0 means use the mode default |
| adc_rst_o | output | 1 | Active-high hardware reset to the converter |
| wr_req_o | output | 1 | Write request to the serial master |
| wr_bank_o | output | 4 | Register bank of the write |
| wr_offs_o | output | 12 | Register offset of the write |
| wr_data_o | output | 8 | Write data |
| wr_ack_i | input | 1 | Write accepted by the serial master |
| sync_o | output | 1 | Link SYNC line |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence complete |
| k_applied_o | output | 5 | K in use |
| ref_max_hz_o | output | 28 | Highest allowed reference-pulse frequency in Hz |

## Verification
Two events can fall in the same cycle: a new start pulse and the last cycle of the SYNC-low phase, when the controller is just finishing. The bench watches its own model and raises start in exactly that cycle. It then checks that the pulse is dropped: busy_o stays low, done_o and sync_o rise and stay high, and k_applied_o does not change. A second collision happens when an acknowledge arrives in the first cycle of a request, so steps advance back to back. The bench varies the acknowledge delay from zero to three cycles to provoke this.

// File: rtl/adc_bringup_pkg.sv
package adc_bringup_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PWR, ST_RST, ST_POST, ST_WR, ST_SYNC
  } seq_state_t;

  typedef struct packed {
    logic [3:0]  bank;
    logic [11:0] offs;
    logic [7:0]  data;
  } wr_step_t;

  localparam int NSTEP = 28;

  // minimum time in ns -> cycles, rounded up, never below one
  function automatic longint ns_to_cycles(longint ns, longint hz);
    longint c;
    c = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
    return (c < 1) ? 64'd1 : c;
  endfunction

  // highest reference-pulse frequency allowed for a given K
  function automatic logic [27:0] ref_limit(int unsigned frame_hz, logic [4:0] k);
    return 28'(frame_hz / (32'(k) + 32'd1));
  endfunction

  function automatic logic [4:0] default_k(logic two_lane);
    return two_lane ? 5'd4 : 5'd8;
  endfunction

endpackage

// File: rtl/bu_delay_timer.sv
module bu_delay_timer #(
  parameter int CW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] limit,
  output logic          fire
);
  logic [CW-1:0] cnt;

  assign fire = run && (cnt == limit - CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || !run || fire) cnt <= '0;
    else                        cnt <= cnt + CW'(1);
  end

  p_cnt_below_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < limit));

endmodule

// File: rtl/bu_k_select.sv
module bu_k_select (
  input  logic       two_lane,
  input  logic [4:0] k_ovr,
  output logic [4:0] k_eff
);
  import adc_bringup_pkg::*;

  assign k_eff = (k_ovr == 5'd0) ? default_k(two_lane) : k_ovr;

  always_comb begin
    a_k_nonzero_r7: assert (k_eff != 5'd0);
  end

endmodule

// File: rtl/bu_script_rom.sv
module bu_script_rom #(
  parameter int IW = 5
) (
  input  logic [IW-1:0]                 idx,
  input  logic                          two_lane,
  input  logic                          high_pass,
  input  logic [4:0]                    k_val,
  output adc_bringup_pkg::wr_step_t     step
);
  import adc_bringup_pkg::*;

  logic [7:0] lane_dig, lane_ana, filt;

  assign lane_dig = two_lane  ? 8'h02 : 8'h01;
  assign lane_ana = two_lane  ? 8'h02 : 8'h00;
  assign filt     = high_pass ? 8'h16 : 8'h12;

  always_comb begin
    case (idx)
      // soft reset and page cleanup
      5'd0:  step = '{4'h0, 12'h000, 8'h81};
      5'd1:  step = '{4'h4, 12'h001, 8'h00};
      5'd2:  step = '{4'h4, 12'h002, 8'h00};
      5'd3:  step = '{4'h4, 12'h003, 8'h00};
      5'd4:  step = '{4'h4, 12'h004, 8'h68};
      5'd5:  step = '{4'h6, 12'h0F7, 8'h01};
      5'd6:  step = '{4'h6, 12'h000, 8'h01};
      5'd7:  step = '{4'h6, 12'h000, 8'h00};
      // performance
      5'd8:  step = '{4'h0, 12'h011, 8'h80};
      5'd9:  step = '{4'h0, 12'h059, 8'h20};
      // lane mode
      5'd10: step = '{4'h4, 12'h003, 8'h00};
      5'd11: step = '{4'h4, 12'h004, 8'h69};
      5'd12: step = '{4'h6, 12'h000, 8'h80};
      5'd13: step = '{4'h6, 12'h001, lane_dig};
      5'd14: step = '{4'h4, 12'h003, 8'h00};
      5'd15: step = '{4'h4, 12'h004, 8'h6A};
      5'd16: step = '{4'h6, 12'h016, lane_ana};
      // filter and apply pulse
      5'd17: step = '{4'h4, 12'h003, 8'h00};
      5'd18: step = '{4'h4, 12'h004, 8'h68};
      5'd19: step = '{4'h6, 12'h052, 8'h80};
      5'd20: step = '{4'h6, 12'h072, 8'h08};
      5'd21: step = '{4'h6, 12'h04D, 8'h08};
      5'd22: step = '{4'h6, 12'h041, filt};
      5'd23: step = '{4'h6, 12'h000, 8'h01};
      5'd24: step = '{4'h6, 12'h000, 8'h00};
      // K
      5'd25: step = '{4'h4, 12'h003, 8'h00};
      5'd26: step = '{4'h4, 12'h004, 8'h69};
      5'd27: step = '{4'h6, 12'h006, {3'b000, k_val}};
      default: step = '{4'h0, 12'h000, 8'h00};
    endcase
  end

endmodule

// File: rtl/adc_link_bringup_seq.sv
module adc_link_bringup_seq #(
  parameter longint      CLK_HZ       = 125_000_000,
  parameter longint      PWRON_NS     = 1_000_000,
  parameter longint      RST_NS       = 10,
  parameter longint      POST_NS      = 100,
  parameter int          SYNC_LOW_CYC = 64,
  parameter int unsigned FRAME_HZ     = 250_000_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        pwr_good_i,
  input  logic        lane2_i,
  input  logic        hpf_i,
  input  logic [4:0]  k_ovr_i,
  output logic        adc_rst_o,
  output logic        wr_req_o,
  output logic [3:0]  wr_bank_o,
  output logic [11:0] wr_offs_o,
  output logic [7:0]  wr_data_o,
  input  logic        wr_ack_i,
  output logic        sync_o,
  output logic        busy_o,
  output logic        done_o,
  output logic [4:0]  k_applied_o,
  output logic [27:0] ref_max_hz_o
);
  import adc_bringup_pkg::*;

  localparam int PWR_CYC  = int'(ns_to_cycles(PWRON_NS, CLK_HZ));
  localparam int RST_CYC  = int'(ns_to_cycles(RST_NS, CLK_HZ));
  localparam int POST_CYC = int'(ns_to_cycles(POST_NS, CLK_HZ));
  localparam int MAX_A    = (PWR_CYC > RST_CYC) ? PWR_CYC : RST_CYC;
  localparam int MAX_B    = (POST_CYC > SYNC_LOW_CYC) ? POST_CYC : SYNC_LOW_CYC;
  localparam int MAXC     = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW       = $clog2(MAXC + 1);
  localparam int IW       = $clog2(NSTEP);

  seq_state_t    state;
  logic [IW-1:0] idx;
  logic          lane2_q, hpf_q;
  logic [4:0]    k_eff;
  logic          sync_q, done_q;
  wr_step_t      step;

  // named internal events
  logic          start_ok, timer_run, timer_fire, step_accept, last_step;
  logic [CW-1:0] timer_limit;

  assign start_ok    = (state == ST_IDLE) && start_i;
  assign step_accept = (state == ST_WR) && wr_ack_i;
  assign last_step   = (idx == IW'(NSTEP - 1));
  assign timer_run   = ((state == ST_PWR) && pwr_good_i) || (state == ST_RST) ||
                       (state == ST_POST) || (state == ST_SYNC);

  always_comb begin
    case (state)
      ST_PWR:  timer_limit = CW'(PWR_CYC);
      ST_RST:  timer_limit = CW'(RST_CYC);
      ST_POST: timer_limit = CW'(POST_CYC);
      ST_SYNC: timer_limit = CW'(SYNC_LOW_CYC);
      default: timer_limit = CW'(1);
    endcase
  end

  bu_delay_timer #(.CW(CW)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (timer_run),
    .limit (timer_limit),
    .fire  (timer_fire)
  );

  bu_k_select u_ksel (
    .two_lane (lane2_i),
    .k_ovr    (k_ovr_i),
    .k_eff    (k_eff)
  );

  bu_script_rom #(.IW(IW)) u_rom (
    .idx       (idx),
    .two_lane  (lane2_q),
    .high_pass (hpf_q),
    .k_val     (k_applied_o),
    .step      (step)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      idx         <= '0;
      lane2_q     <= 1'b0;
      hpf_q       <= 1'b0;
      k_applied_o <= 5'd8;
      sync_q      <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start_ok) begin
          state       <= ST_PWR;
          lane2_q     <= lane2_i;
          hpf_q       <= hpf_i;
          k_applied_o <= k_eff;
          sync_q      <= 1'b0;
          done_q      <= 1'b0;
        end
        ST_PWR:  if (timer_fire) state <= ST_RST;
        ST_RST:  if (timer_fire) state <= ST_POST;
        ST_POST: if (timer_fire) begin
          state <= ST_WR;
          idx   <= '0;
        end
        ST_WR: if (step_accept) begin
          if (last_step) state <= ST_SYNC;
          else           idx   <= idx + IW'(1);
        end
        ST_SYNC: if (timer_fire) begin
          state  <= ST_IDLE;
          sync_q <= 1'b1;
          done_q <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign adc_rst_o    = (state == ST_RST);
  assign wr_req_o     = (state == ST_WR);
  assign wr_bank_o    = step.bank;
  assign wr_offs_o    = step.offs;
  assign wr_data_o    = step.data;
  assign sync_o       = sync_q;
  assign done_o       = done_q;
  assign busy_o       = (state != ST_IDLE);
  assign ref_max_hz_o = ref_limit(FRAME_HZ, k_applied_o);

  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req_o && !wr_ack_i |=> wr_req_o && $stable(wr_bank_o) &&
                              $stable(wr_offs_o) && $stable(wr_data_o));

  p_no_write_in_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    adc_rst_o |-> !wr_req_o);

  p_busy_done_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && done_o));

  p_k_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(k_applied_o));

  p_sync_after_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sync_o |-> !busy_o && !adc_rst_o);

  p_k_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    k_applied_o != 5'd0);

endmodule

// File: tb/adc_link_bringup_seq_tb.sv
module adc_link_bringup_seq_tb;

  localparam int CLK_MHZ   = 125;
  localparam int PWR_NS_TB = 2000;
  localparam int SYNC_LOW  = 20;
  // ceiling of ns * MHz / 1000
  localparam int E_PWR  = (PWR_NS_TB * CLK_MHZ + 999) / 1000;
  localparam int E_RST  = (10 * CLK_MHZ + 999) / 1000;
  localparam int E_POST = (100 * CLK_MHZ + 999) / 1000;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0, start = 1'b0, pg = 1'b0, l2 = 1'b0, hp = 1'b0, ack = 1'b0;
  logic [4:0]  kovr = 5'd0;
  logic        adc_rst, req, sync, busy, done;
  logic [3:0]  bank;
  logic [11:0] offs;
  logic [7:0]  data;
  logic [4:0]  kap;
  logic [27:0] refmax;

  adc_link_bringup_seq #(
    .CLK_HZ(125_000_000), .PWRON_NS(PWR_NS_TB), .RST_NS(10), .POST_NS(100),
    .SYNC_LOW_CYC(SYNC_LOW), .FRAME_HZ(250_000_000)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .pwr_good_i(pg), .lane2_i(l2),
    .hpf_i(hp), .k_ovr_i(kovr), .adc_rst_o(adc_rst), .wr_req_o(req),
    .wr_bank_o(bank), .wr_offs_o(offs), .wr_data_o(data), .wr_ack_i(ack),
    .sync_o(sync), .busy_o(busy), .done_o(done), .k_applied_o(kap),
    .ref_max_hz_o(refmax)
  );

  int checks = 0, errors = 0, writes = 0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: 0 idle,1 power wait,2 reset,3 gap,4 writing,5 sync low
  int         m_phase = 0, m_cnt = 0;
  bit         m_sync = 0, m_done = 0;
  int         m_k = 8;
  logic [23:0] q[$];

  task automatic build_script(input bit two, input bit hpf, input int k);
    q.delete();
    q.push_back({4'h0,12'h000,8'h81}); q.push_back({4'h4,12'h001,8'h00});
    q.push_back({4'h4,12'h002,8'h00}); q.push_back({4'h4,12'h003,8'h00});
    q.push_back({4'h4,12'h004,8'h68}); q.push_back({4'h6,12'h0F7,8'h01});
    q.push_back({4'h6,12'h000,8'h01}); q.push_back({4'h6,12'h000,8'h00});
    q.push_back({4'h0,12'h011,8'h80}); q.push_back({4'h0,12'h059,8'h20});
    q.push_back({4'h4,12'h003,8'h00}); q.push_back({4'h4,12'h004,8'h69});
    q.push_back({4'h6,12'h000,8'h80});
    q.push_back({4'h6,12'h001, two ? 8'h02 : 8'h01});
    q.push_back({4'h4,12'h003,8'h00}); q.push_back({4'h4,12'h004,8'h6A});
    q.push_back({4'h6,12'h016, two ? 8'h02 : 8'h00});
    q.push_back({4'h4,12'h003,8'h00}); q.push_back({4'h4,12'h004,8'h68});
    q.push_back({4'h6,12'h052,8'h80}); q.push_back({4'h6,12'h072,8'h08});
    q.push_back({4'h6,12'h04D,8'h08});
    q.push_back({4'h6,12'h041, hpf ? 8'h16 : 8'h12});
    q.push_back({4'h6,12'h000,8'h01}); q.push_back({4'h6,12'h000,8'h00});
    q.push_back({4'h4,12'h003,8'h00}); q.push_back({4'h4,12'h004,8'h69});
    q.push_back({4'h6,12'h006, 8'(k)});
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_cnt = 0; m_sync = 0; m_done = 0; m_k = 8; q.delete();
    end else begin
      case (m_phase)
        0: if (start) begin
          m_k = (kovr == 0) ? (l2 ? 4 : 8) : int'(kovr);
          build_script(l2, hp, m_k);
          m_sync = 0; m_done = 0; m_phase = 1; m_cnt = 0;
        end
        1: if (!pg) m_cnt = 0;
           else if (m_cnt == E_PWR - 1) begin m_phase = 2; m_cnt = 0; end
           else m_cnt++;
        2: if (m_cnt == E_RST - 1) begin m_phase = 3; m_cnt = 0; end else m_cnt++;
        3: if (m_cnt == E_POST - 1) begin m_phase = 4; m_cnt = 0; end else m_cnt++;
        4: if (ack) begin
          void'(q.pop_front());
          writes++;
          if (q.size() == 0) begin m_phase = 5; m_cnt = 0; end
        end
        5: if (m_cnt == SYNC_LOW - 1) begin
          m_phase = 0; m_sync = 1; m_done = 1;
        end else m_cnt++;
        default: m_phase = 0;
      endcase
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R2 R3 adc_rst", adc_rst, m_phase == 2);
      chk("R6 wr_req", req, m_phase == 4);
      if (m_phase == 4 && q.size() > 0) begin
        chk("R4 R5 bank", bank, q[0][23:20]);
        chk("R4 R5 offset", offs, q[0][19:8]);
        chk("R4 R5 R7 data", data, q[0][7:0]);
      end
      chk("R10 busy", busy, m_phase != 0);
      chk("R9 R10 done", done, m_done);
      chk("R9 sync", sync, m_sync);
      chk("R7 k_applied", kap, m_k);
      chk("R8 ref_max", refmax, 250000000 / (m_k + 1));
    end
  end

  // acknowledge driver with a rotating delay of 0..3 cycles
  int ack_wait = 0, ack_dly = 0;
  always @(negedge clk) begin
    if (req) begin
      if (ack_wait >= ack_dly) begin
        ack = 1'b1; ack_wait = 0; ack_dly = (ack_dly + 1) % 4;
      end else begin
        ack = 1'b0; ack_wait++;
      end
    end else ack = 1'b0;
  end

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run(input bit two, input bit hpf, input logic [4:0] ko,
                     input int exp_k, input int exp_ref, input bit collide);
    int w0;
    w0 = writes;
    l2 = two; hp = hpf; kovr = ko;
    @(negedge clk);
    pulse_start();
    // a start while busy must leave everything unchanged (R10)
    while (m_phase != 4) @(negedge clk);
    l2 = ~two; kovr = 5'd3;
    pulse_start();
    if (collide) begin
      while (!(m_phase == 5 && m_cnt == SYNC_LOW - 1)) @(negedge clk);
      pulse_start();   // lands in the final SYNC-low cycle
    end
    while (m_phase != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R10 idle after run", busy, 0);
    chk("R9 done held", done, 1);
    chk("R9 sync high", sync, 1);
    chk("R7 applied K", kap, exp_k);
    chk("R8 ref limit", refmax, exp_ref);
    chk("R4 write count", writes - w0, 28);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rst_out", adc_rst, 0); chk("R1 req", req, 0);
    chk("R1 busy", busy, 0); chk("R1 done", done, 0); chk("R1 sync", sync, 0);
    chk("R1 k", kap, 8); chk("R1 ref", refmax, 27777777);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after release", busy, 0);

    // run 1: four lanes, low-pass, default K, power-good glitch (R2)
    l2 = 1'b0; hp = 1'b0; kovr = 5'd0;
    @(negedge clk);
    pulse_start();
    repeat (30) @(negedge clk);
    pg = 1'b1;
    repeat (100) @(negedge clk);
    pg = 1'b0;
    repeat (3) @(negedge clk);
    pg = 1'b1;
    while (m_phase != 4) @(negedge clk);
    pulse_start();   // ignored while busy (R10)
    while (m_phase != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R7 default K four-lane", kap, 8);
    chk("R8 ref for K=8", refmax, 27777777);
    chk("R9 done after run 1", done, 1);

    // run 2: two lanes, high-pass, default K
    run(1'b1, 1'b1, 5'd0, 4, 50000000, 1'b0);
    // run 3: four lanes, high-pass, K=31, start collides with the end
    run(1'b0, 1'b1, 5'd31, 31, 7812500, 1'b1);
    // run 4: two lanes, low-pass, K=12
    run(1'b1, 1'b0, 5'd12, 12, 19230769, 1'b0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog R10 actual=busy expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule